// File: doc/BRIEF.md
# External Bus Hand-Over Controller

This block lets an outside master borrow the external bus of a microcontroller. It watches a bus request input. When a control bit permits hand-over, it waits until the internal bus sequencer is between accesses. It then floats the address, upper data and read-strobe pins, and one clock later it signals the hand-over on an active-low grant output. While the outside master holds the bus, the internal sequencer is told to stall.

When the request is withdrawn, the controller takes the bus back in a fixed order. It first negates the grant while the pins are still floating, and one clock later it drives the pins again. Each direction therefore has a one-clock dead cycle, so the two masters never drive the same wires in the same cycle. The request input is asynchronous to the controller and passes through a synchronizer before the state machine uses it.

Top module: `bus_hold_ctrl`

## Requirements
- R1: After reset, `grant_n` is 1, every bit of `addr_oe`, `data_oe` and `strobe_oe` is 1 (pins driven) and `seq_stall` is 0.
- R2: While `rel_en` is 0 and the controller owns the bus, `bus_req` has no effect: `grant_n` stays 1 and all output enables stay 1.
- R3: On release, all output enables go to 0 on the same clock edge, and `grant_n` is still 1 in that cycle.
- R4: `grant_n` goes to 0 exactly one clock after the output enables go to 0.
- R5: On reacquisition, `grant_n` returns to 1 while the output enables are still 0, and the output enables return to 1 exactly one clock later.
- R6: The pins are floated only on an edge where `seq_idle` was 1; while `seq_idle` is 0 a pending request waits.
- R7: `seq_stall` is 1 whenever the pins are not driven or the grant is asserted, and also in the cycle where release is committed (owned, `rel_en`=1, synchronized request 1, `seq_idle`=1).
- R8: Clearing `rel_en` while the grant is asserted does not reclaim the bus; hand-back starts only when the synchronized request is 0.
- R9: `bus_req` passes through `SYNC_STAGES` flops (default 2). With `rel_en`=1 and `seq_idle`=1, the output enables fall on the third rising edge after `bus_req` rises, and not before.
- R10: The release sequence is fixed. A request that is dropped after it has been committed still produces a float cycle and one grant cycle, and then the normal reacquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rel_en | input | 1 | Control bit permitting bus hand-over |
| bus_req | input | 1 | Asynchronous bus request from the outside master, active high |
| seq_idle | input | 1 | Internal sequencer is at an access boundary |
| grant_n | output | 1 | Active-low bus grant to the outside master |
| seq_stall | output | 1 | Forbids the internal sequencer from starting an external access |
| addr_oe | output | ADDR_W | Output enables for the address pins, 1 = driven |
| data_oe | output | DATA_W | Output enables for the upper data pins, 1 = driven |
| strobe_oe | output | 1 | Output enable for the read strobe, 1 = driven |

## Verification
The assertions assume that `seq_idle` comes from the internal sequencer and obeys `seq_stall`. They also assume that `rel_en` and `bus_req` are only sampled through the controller's own registers, so nothing outside the block orders the pins. The bench changes every input just after a falling edge, so each input is stable around the rising edge that samples it. It raises `seq_idle` only while no access would be in flight. The directed sequences hold `bus_req` long enough to pass the synchronizer, except for the single-cycle pulse that deliberately tests the fixed release sequence.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic [1:0] {
    ST_OWN     = 2'd0,
    ST_FLOAT   = 2'd1,
    ST_GRANTED = 2'd2,
    ST_RECLAIM = 2'd3
  } bhc_state_e;

  // Pins are driven only while the controller owns the bus.
  function automatic logic pins_driven(bhc_state_e s);
    return (s == ST_OWN);
  endfunction

  // Grant is asserted (low at the pin) only in the granted state.
  function automatic logic grant_active(bhc_state_e s);
    return (s == ST_GRANTED);
  endfunction

  // A release is committed at a sequencer boundary with the feature enabled.
  function automatic logic commit_release(bhc_state_e s, logic en, logic req, logic idle);
    return (s == ST_OWN) && en && req && idle;
  endfunction

  function automatic bhc_state_e next_state(bhc_state_e s, logic en, logic req, logic idle);
    bhc_state_e n;
    n = s;
    unique case (s)
      ST_OWN:     if (commit_release(s, en, req, idle)) n = ST_FLOAT;
      ST_FLOAT:   n = ST_GRANTED;
      ST_GRANTED: if (!req) n = ST_RECLAIM;
      ST_RECLAIM: n = ST_OWN;
      default:    n = ST_OWN;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d_async;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bhc_oe_fan.sv
module bhc_oe_fan #(
  parameter int W = 8
) (
  input  logic         drive,
  output logic [W-1:0] oe
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign oe[g] = drive;
    end
  endgenerate
endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
  import bhc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rel_en,
  input  logic req_s,
  input  logic seq_idle,
  output logic drive_pins,
  output logic grant_on,
  output logic stall
);
  bhc_state_e state_q, state_d;
  logic       commit_now;

  assign commit_now = commit_release(state_q, rel_en, req_s, seq_idle);
  assign state_d    = next_state(state_q, rel_en, req_s, seq_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OWN;
    else        state_q <= state_d;
  end

  assign drive_pins = pins_driven(state_q);
  assign grant_on   = grant_active(state_q);
  assign stall      = !drive_pins || grant_on || commit_now;

  // R2: disabled feature never starts a release
  p_disabled_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OWN && !rel_en) |=> drive_pins);

  // R6: pins float only after an idle boundary
  p_idle_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_pins) |-> $past(seq_idle));

  // R8: grant held while the synchronized request stays high
  p_hold_while_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_on && req_s) |=> grant_on);

  // R10: a committed release always reaches the grant
  p_fixed_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_pins) |=> grant_on);
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int ADDR_W      = 25,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rel_en,
  input  logic              bus_req,
  input  logic              seq_idle,
  output logic              grant_n,
  output logic              seq_stall,
  output logic [ADDR_W-1:0] addr_oe,
  output logic [DATA_W-1:0] data_oe,
  output logic              strobe_oe
);
  logic req_s;
  logic drive_pins;
  logic grant_on;
  logic stall;

  bhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (bus_req),
    .q_sync  (req_s)
  );

  bhc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rel_en     (rel_en),
    .req_s      (req_s),
    .seq_idle   (seq_idle),
    .drive_pins (drive_pins),
    .grant_on   (grant_on),
    .stall      (stall)
  );

  bhc_oe_fan #(.W(ADDR_W)) u_addr_fan (.drive(drive_pins), .oe(addr_oe));
  bhc_oe_fan #(.W(DATA_W)) u_data_fan (.drive(drive_pins), .oe(data_oe));
  bhc_oe_fan #(.W(1))      u_strb_fan (.drive(drive_pins), .oe(strobe_oe));

  assign grant_n   = !grant_on;
  assign seq_stall = stall;

  // R3: all groups switch together
  p_groups_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe == {ADDR_W{strobe_oe}}) && (data_oe == {DATA_W{strobe_oe}}));

  // R3: grant never low in the cycle the pins first float
  p_float_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_oe) |-> grant_n);

  // R4: grant follows the float by exactly one clock
  p_grant_after_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_oe) |=> $fell(grant_n));

  // R5: grant negated first, pins driven one clock later
  p_reclaim_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_n) |-> (!strobe_oe ##1 $rose(strobe_oe)));

  // R5: never driving pins while the grant is out
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!grant_n && strobe_oe));

  // R7: sequencer stalled whenever the bus is not ours
  p_stall_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_oe || !grant_n) |-> seq_stall);
endmodule

// File: tb/test_bus_hold_ctrl.sv
`timescale 1ns/1ps
module test_bus_hold_ctrl;
  localparam int AW = 25;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rel_en = 1'b0;
  logic bus_req = 1'b0;
  logic seq_idle = 1'b1;
  logic grant_n;
  logic seq_stall;
  logic [AW-1:0] addr_oe;
  logic [DW-1:0] data_oe;
  logic strobe_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_hold_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) i_bus_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .rel_en(rel_en), .bus_req(bus_req),
    .seq_idle(seq_idle), .grant_n(grant_n), .seq_stall(seq_stall),
    .addr_oe(addr_oe), .data_oe(data_oe), .strobe_oe(strobe_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // pins code: 1 = all driven, 0 = all floating, 2 = mixed
  function automatic int pins_code();
    if (&addr_oe && &data_oe && strobe_oe) return 1;
    if (addr_oe == '0 && data_oe == '0 && !strobe_oe) return 0;
    return 2;
  endfunction

  task automatic expect_state(input string tag, input int pins, input int gn);
    chk(pins_code() == pins, {tag, " pins"}, pins_code(), pins);
    chk(int'(grant_n) == gn, {tag, " grant_n"}, int'(grant_n), gn);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    step(1);
    expect_state("R1 in reset", 1, 1);
    rst_n = 1'b1;
    step(1);
    expect_state("R1 after reset", 1, 1);
    chk(seq_stall == 1'b0, "R1 stall", int'(seq_stall), 0);
  endtask

  task automatic t_disabled();
    rel_en = 1'b0;
    bus_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      expect_state("R2 disabled", 1, 1);
    end
    bus_req = 1'b0;
    step(3);
  endtask

  task automatic t_release_reclaim();
    rel_en = 1'b1;
    seq_idle = 1'b1;
    bus_req = 1'b1;
    step(1);
    expect_state("R9 edge1", 1, 1);
    step(1);
    expect_state("R9 edge2", 1, 1);
    chk(seq_stall == 1'b1, "R7 commit cycle stall", int'(seq_stall), 1);
    step(1);
    expect_state("R3 float", 0, 1);
    chk(seq_stall == 1'b1, "R7 float stall", int'(seq_stall), 1);
    step(1);
    expect_state("R4 grant", 0, 0);
    step(3);
    expect_state("R4 grant held", 0, 0);
    bus_req = 1'b0;
    step(2);
    expect_state("R5 sync delay", 0, 0);
    step(1);
    expect_state("R5 grant first", 0, 1);
    chk(seq_stall == 1'b1, "R7 reclaim stall", int'(seq_stall), 1);
    step(1);
    expect_state("R5 pins back", 1, 1);
    chk(seq_stall == 1'b0, "R7 stall released", int'(seq_stall), 0);
  endtask

  task automatic t_busy();
    seq_idle = 1'b0;
    bus_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1);
      expect_state("R6 busy waits", 1, 1);
    end
    seq_idle = 1'b1;
    step(1);
    expect_state("R6 float after idle", 0, 1);
    step(1);
    expect_state("R6 grant", 0, 0);
    bus_req = 1'b0;
    step(4);
    expect_state("R6 reclaimed", 1, 1);
  endtask

  task automatic t_enable_clear();
    rel_en = 1'b1;
    bus_req = 1'b1;
    step(4);
    expect_state("R8 granted", 0, 0);
    rel_en = 1'b0;
    step(4);
    expect_state("R8 still granted", 0, 0);
    bus_req = 1'b0;
    step(3);
    expect_state("R8 grant negated", 0, 1);
    step(1);
    expect_state("R8 pins back", 1, 1);
    rel_en = 1'b1;
    step(2);
  endtask

  task automatic t_pulse();
    bus_req = 1'b1;
    step(1);
    bus_req = 1'b0;
    step(1);
    expect_state("R10 pre", 1, 1);
    step(1);
    expect_state("R10 float", 0, 1);
    step(1);
    expect_state("R10 one grant", 0, 0);
    step(1);
    expect_state("R10 reclaim", 0, 1);
    step(1);
    expect_state("R10 owned", 1, 1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_release_reclaim();
    t_busy();
    t_enable_clear();
    t_pulse();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule